// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Source

This block drives one serial bit per clock for link testing. It runs in one of two modes. In pseudorandom mode the sequence comes from a shift register with two XOR feedback taps. The first tap is fixed by a 5-bit length code and the second is set by a 5-bit tap code. In repetitive mode a user word of 1 to 32 bits is sent again and again. One shift register serves both modes. In pseudorandom mode the word must be all ones. In repetitive mode the word holds the pattern.

Four stages act on the bit stream after the generator, in this order:
- An optional zero-suppression stage limits runs of zeros.
- A decade scheduler inverts one bit in every 10^k transmitted bits.
- A single-error strobe inverts one chosen bit.
- A global inversion control complements every bit.

A hold input freezes the output and the generator. A rising edge on the load input restarts the pattern from the word.

Top module: `tpat_source`

## Requirements
- R1: After reset, `tx_data` is 0 and stays 0 until a load.
- R2: In repetitive mode (`prbs_mode`=0) with length code L, the stream is `pattern_word[L]`, `pattern_word[L-1]`, ..., `pattern_word[0]`, and then repeats with period L+1. The tap code has no effect in this mode.
- R3: A rising edge of `load` at clock edge e reloads the generator from `pattern_word`, and `tx_data` does not change at edge e. The first bit of the new pattern appears on `tx_data` after edge e+1. The reload also happens while `hold` is high.
- R4: While `hold` is 1 at a rising edge, `tx_data` keeps its value, and neither the generator nor the error scheduler advances.
- R5: In pseudorandom mode with length code L and tap code T, the bits are o0..oL = `pattern_word[L..0]`. Every later bit is o(n) = o(n-L-1) XOR o(n-1-T).
- R6: Error-rate code k (1..7) inverts bits 10^k-1, 2·10^k-1, and so on. Bits are counted from 0 after a load, and only bits actually transmitted are counted. Code 0 inserts no errors.
- R7: A rising edge of `single_err` inverts exactly the next transmitted bit, only once. `single_err` must fall and rise again before it inserts another error. If that bit is also a scheduled error, it is still inverted only once.
- R8: With `zsup_en`=1 and length code of at least 13, a bit is sent as 1 whenever it and the 13 generator bits after it are all 0. With a length code below 13, zero suppression has no effect.
- R9: With `invert_en`=1, every transmitted bit is complemented, after the error and suppression stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pattern_word | input | 32 | Seed (all ones) or repeated pattern |
| len_code | input | 5 | Pattern length minus one; first feedback tap |
| tap_code | input | 5 | Second feedback tap position |
| prbs_mode | input | 1 | 1 = pseudorandom, 0 = repetitive |
| zsup_en | input | 1 | Zero-suppression enable |
| invert_en | input | 1 | Complement every output bit |
| err_rate | input | 3 | Decade error-rate code |
| single_err | input | 1 | Single-error strobe, edge sensitive |
| load | input | 1 | Reload strobe, edge sensitive |
| hold | input | 1 | Freeze output and generator |
| tx_data | output | 1 | Serial test data |

## Verification
A scheduled decade error and a single-error strobe can land on the same transmitted bit. To provoke this, the bench runs error-rate code 1 and raises `single_err` in the interval just before bit 19, which is also a scheduled error bit. The bench then checks that bit 19 differs from the clean pattern exactly once (it is inverted, not inverted twice back to its true value). It also checks that a later lone strobe still inverts only its own bit.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  // Interval of the decade error scheduler: 10^code, or 0 when disabled.
  function automatic int unsigned dec_period(input logic [2:0] code);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 7; i++) begin
      if (i < int'(code)) p = p * 10;
    end
    return (code == 3'd0) ? 0 : p;
  endfunction

endpackage

// File: rtl/tpat_edge.sv
module tpat_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/tpat_core.sv
module tpat_core #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5,
  parameter int ZS_WIN = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  tap,
  input  logic              prbs,
  input  logic              zsup_en,
  input  logic              load_now,
  input  logic              advance,
  output logic              raw_bit,
  output logic              zs_force
);
  localparam logic [LEN_W-1:0] ZS_MIN_LEN = LEN_W'(ZS_WIN - 1);

  logic [WORD_W-1:0] sr;
  logic              feedback;
  logic              window_zero;

  assign raw_bit  = sr[len];
  assign feedback = sr[len] ^ (prbs & sr[tap]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (load_now) sr <= word;
    else if (advance)  sr <= {sr[WORD_W-2:0], feedback};
  end

  // Look ahead over the bits that will be sent next.
  always_comb begin
    window_zero = 1'b1;
    for (int i = 0; i < ZS_WIN; i++) begin
      if (LEN_W'(i) <= len) window_zero = window_zero & ~sr[len - LEN_W'(i)];
    end
  end

  assign zs_force = zsup_en & (len >= ZS_MIN_LEN) & window_zero;

  assert_load_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (sr == $past(word)));

  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load_now) |=> $stable(sr));
endmodule

// File: rtl/tpat_errsched.sv
module tpat_errsched
  import tpat_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              strobe_rise,
  input  logic              load_now,
  input  logic              advance,
  output logic              sched_hit,
  output logic              single_fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             pending;

  always_comb begin
    if (rate == '0) reload = '0;
    else            reload = CNT_W'(dec_period(3'(rate)) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_now) begin
      cnt <= reload;
    end else if (advance) begin
      if (rate == '0)      cnt <= '0;
      else if (cnt == '0)  cnt <= reload;
      else                 cnt <= cnt - 1'b1;
    end
  end

  assign sched_hit   = advance & (rate != '0) & (cnt == '0);
  assign single_fire = advance & (pending | strobe_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending | strobe_rise) & ~advance;
  end

  assert_reload_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sched_hit |=> (cnt == $past(reload)));

  assert_single_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    single_fire |=> !pending);
endmodule

// File: rtl/tpat_source.sv
module tpat_source #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5,
  parameter int RATE_W = 3,
  parameter int CNT_W  = 24,
  parameter int ZS_WIN = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pattern_word,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [LEN_W-1:0]  tap_code,
  input  logic              prbs_mode,
  input  logic              zsup_en,
  input  logic              invert_en,
  input  logic [RATE_W-1:0] err_rate,
  input  logic              single_err,
  input  logic              load,
  input  logic              hold,
  output logic              tx_data
);
  localparam int N_STROBE = 2;

  logic [N_STROBE-1:0] strobe_in;
  logic [N_STROBE-1:0] strobe_rise;
  logic load_now, err_rise, advance;
  logic raw_bit, zs_force, sched_hit, single_fire, err_any, next_bit;
  logic tx_q;

  assign strobe_in = {single_err, load};

  for (genvar g = 0; g < N_STROBE; g++) begin : g_edge
    tpat_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (strobe_in[g]),
      .rise (strobe_rise[g])
    );
  end

  assign load_now = strobe_rise[0];
  assign err_rise = strobe_rise[1];
  assign advance  = ~hold & ~load_now;

  tpat_core #(.WORD_W(WORD_W), .LEN_W(LEN_W), .ZS_WIN(ZS_WIN)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .word    (pattern_word),
    .len     (len_code),
    .tap     (tap_code),
    .prbs    (prbs_mode),
    .zsup_en (zsup_en),
    .load_now(load_now),
    .advance (advance),
    .raw_bit (raw_bit),
    .zs_force(zs_force)
  );

  tpat_errsched #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate       (err_rate),
    .strobe_rise(err_rise),
    .load_now   (load_now),
    .advance    (advance),
    .sched_hit  (sched_hit),
    .single_fire(single_fire)
  );

  // Two coincident error sources still flip the bit only once.
  assign err_any  = sched_hit | single_fire;
  assign next_bit = (raw_bit | zs_force) ^ err_any ^ invert_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_q <= 1'b0;
    else if (advance) tx_q <= next_bit;
  end

  assign tx_data = tx_q;

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(tx_data));

  assert_load_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> $stable(tx_data));
endmodule

// File: tb/tpat_source_tb.sv
module tpat_source_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pattern_word = '0;
  logic [4:0]  len_code = '0, tap_code = '0;
  logic        prbs_mode = 0, zsup_en = 0, invert_en = 0;
  logic [2:0]  err_rate = '0;
  logic        single_err = 0, load = 0, hold = 0;
  logic        tx_data;

  int n_checks = 0, n_fail = 0;
  bit raw [0:799];
  bit expv[0:799];

  always #2 clk = ~clk;

  tpat_source u_dut (
    .clk(clk), .rst_n(rst_n), .pattern_word(pattern_word), .len_code(len_code),
    .tap_code(tap_code), .prbs_mode(prbs_mode), .zsup_en(zsup_en),
    .invert_en(invert_en), .err_rate(err_rate), .single_err(single_err),
    .load(load), .hold(hold), .tx_data(tx_data)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference stream built from the requirement equations.
  task automatic model(input bit prbs, input int len, input int tap, input logic [31:0] w,
                       input bit zs, input bit inv, input int period, input int n);
    for (int j = 0; j < n + 14; j++) begin
      if (j <= len)     raw[j] = w[len - j];
      else if (prbs)    raw[j] = raw[j-len-1] ^ raw[j-1-tap];
      else              raw[j] = raw[j-len-1];
    end
    for (int j = 0; j < n; j++) begin
      bit z;
      z = zs && (len >= 13);
      for (int k = 0; k < 14; k++) if (raw[j+k]) z = 0;
      expv[j] = raw[j] | z;
      if (period > 0 && ((j + 1) % period) == 0) expv[j] = ~expv[j];
      expv[j] = expv[j] ^ inv;
    end
  endtask

  task automatic cfg(input bit prbs, input int len, input int tap, input logic [31:0] w,
                     input bit zs, input bit inv, input int rate);
    prbs_mode = prbs; len_code = 5'(len); tap_code = 5'(tap); pattern_word = w;
    zsup_en = zs; invert_en = inv; err_rate = 3'(rate);
  endtask

  task automatic do_load();
    load = 1; step(); load = 0;
  endtask

  task automatic run_bits(input string req, input int first, input int n);
    for (int j = first; j < first + n; j++) begin
      step();
      check(tx_data === expv[j], req, tx_data, expv[j]);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) step(); rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      check(tx_data === 1'b0, "R1 reset output", tx_data, 0);
    end
  endtask

  task automatic t_repeat();
    cfg(0, 7, 3, 32'h0000_00B4, 0, 0, 0);
    model(0, 7, 3, 32'h0000_00B4, 0, 0, 0, 40);
    do_load();
    run_bits("R2 repetitive 8-bit, R3 load latency", 0, 40);
    cfg(0, 0, 0, 32'h0000_0001, 0, 0, 0);
    model(0, 0, 0, 32'h0000_0001, 0, 0, 0, 10);
    do_load();
    run_bits("R2 one-bit pattern", 0, 10);
    cfg(0, 31, 9, 32'hA5C3_0F96, 0, 0, 0);
    model(0, 31, 9, 32'hA5C3_0F96, 0, 0, 0, 80);
    do_load();
    run_bits("R2 32-bit pattern", 0, 80);
  endtask

  task automatic t_prbs();
    cfg(1, 6, 0, 32'hFFFF_FFFF, 0, 0, 0);
    model(1, 6, 0, 32'hFFFF_FFFF, 0, 0, 0, 300);
    do_load();
    run_bits("R5 prbs len6 tap0", 0, 300);
    cfg(1, 22, 17, 32'hFFFF_FFFF, 0, 0, 0);
    model(1, 22, 17, 32'hFFFF_FFFF, 0, 0, 0, 300);
    do_load();
    run_bits("R5 prbs len22 tap17", 0, 300);
  endtask

  task automatic t_hold();
    cfg(0, 7, 0, 32'h0000_00B4, 0, 0, 0);
    model(0, 7, 0, 32'h0000_00B4, 0, 0, 0, 40);
    do_load();
    run_bits("R4 pre-hold", 0, 6);
    hold = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(tx_data === expv[5], "R4 held bit", tx_data, expv[5]);
    end
    hold = 0;
    run_bits("R4 resume after hold", 6, 10);
    hold = 1; load = 1; step();
    check(tx_data === expv[15], "R3 load edge keeps output", tx_data, expv[15]);
    load = 0; step();
    check(tx_data === expv[15], "R4 hold after load", tx_data, expv[15]);
    hold = 0;
    run_bits("R3 load applied during hold", 0, 12);
  endtask

  task automatic t_errors();
    cfg(0, 7, 0, 32'h0000_00B4, 0, 0, 1);
    model(0, 7, 0, 32'h0000_00B4, 0, 0, 10, 60);
    do_load();
    run_bits("R6 rate code 1", 0, 60);
    cfg(1, 6, 0, 32'hFFFF_FFFF, 0, 0, 2);
    model(1, 6, 0, 32'hFFFF_FFFF, 0, 0, 100, 250);
    do_load();
    run_bits("R6 rate code 2", 0, 250);
  endtask

  task automatic t_single();
    cfg(0, 7, 0, 32'h0000_00B4, 0, 0, 1);
    model(0, 7, 0, 32'h0000_00B4, 0, 0, 10, 40);
    expv[24] = ~expv[24];
    do_load();
    for (int j = 0; j < 40; j++) begin
      step();
      check(tx_data === expv[j], "R7 single error and coincidence", tx_data, expv[j]);
      if (j == 18) single_err = 1;
      if (j == 20) single_err = 0;
      if (j == 23) single_err = 1;
      if (j == 27) single_err = 0;
    end
    err_rate = 0;
  endtask

  task automatic t_zsup();
    cfg(0, 31, 0, 32'h8000_0FFF, 1, 0, 0);
    model(0, 31, 0, 32'h8000_0FFF, 1, 0, 0, 70);
    do_load();
    run_bits("R8 zero suppression active", 0, 70);
    cfg(0, 8, 0, 32'h0000_0100, 1, 0, 0);
    model(0, 8, 0, 32'h0000_0100, 1, 0, 0, 30);
    do_load();
    run_bits("R8 zero suppression off below 13", 0, 30);
  endtask

  task automatic t_invert();
    cfg(0, 7, 0, 32'h0000_00B4, 0, 1, 0);
    model(0, 7, 0, 32'h0000_00B4, 0, 1, 0, 24);
    do_load();
    run_bits("R9 inversion", 0, 24);
    invert_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_repeat();
    t_prbs();
    t_hold();
    t_errors();
    t_single();
    t_zsup();
    t_invert();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule